// File: doc/BRIEF.md
# S/PDIF Channel-Status and User-Bit Capture

This block sits behind a subframe decoder in an S/PDIF receive path. For every decoded subframe it receives a strobe, the channel index, the channel-status (C) bit, the user (U) bit and a flag that marks the first frame of a 192-frame block. Per channel it gathers the C bits and the U bits into two 192-bit fields. When every channel holds a full block, all fields are copied at once into a visible bank.

Software, or a neighbouring register block, reads the visible bank as 32-bit words through a combinational address port. The block also produces one-cycle event pulses: block start, block end, and a per-channel status-changed pulse. The status-changed pulse tells a channel whose newly completed channel-status block differs from the one it replaces.

A block that is cut short by a fresh start marker is thrown away and collection begins again. Subframes that arrive while no block is being gathered have no effect.

Top module: `spdif_aux_capture`

## Requirements
- R1: After reset every mapped word reads 0, every event output is low, and subframes are not collected until the first subframe carrying the start marker.
- R2: A valid subframe with `sf_blk_mark` high starts a block and is bit 0 of its own channel. Bit i of a channel's field is the C (or U) bit of the i-th subframe of that channel since the marker. `ev_blk_start` is high for exactly the one cycle after the marked subframe is sampled.
- R3: Bit i of a field sits in word i/32 at bit position i%32, so the earliest bits are in the least significant byte. Status word k of channel n is at byte address 0x30 + 0x30*n + 4*k and user word k at 0x48 + 0x30*n + 4*k, with k = 0..5. Every other address, including any address with nonzero low two bits, reads 0.
- R4: A block completes on the subframe that gives the last channel its 192nd bit. `ev_blk_end` is high for the one cycle after that subframe is sampled, and in that same cycle all words of all channels show the new block.
- R5: The visible words change only in a cycle where `ev_blk_end` is high. A partly collected block is never visible.
- R6: `ev_cs_chg[n]` pulses together with `ev_blk_end` exactly when channel n's new status field differs from the one it replaces (the stored field is 0 after reset), and stays low otherwise.
- R7: User words are replaced at every block end, even when no status-changed pulse is raised.
- R8: A start marker arriving before a block completes discards the partial block. No block-end pulse is raised for it, the visible words keep the last completed block, and collection restarts from the marker.
- R9: Unmarked subframes that arrive while no block is in progress (after reset or after completion), and extra subframes for a channel that already holds 192 bits, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sf_valid | input | 1 | One decoded subframe is present this cycle |
| sf_chan | input | 1 | Channel index of the subframe (CH_W bits) |
| sf_cbit | input | 1 | Channel-status bit of the subframe |
| sf_ubit | input | 1 | User bit of the subframe |
| sf_blk_mark | input | 1 | Subframe is the first of a new block |
| rd_addr | input | 8 | Byte address of the word to read (ADDR_W bits) |
| rd_data | output | 32 | Addressed word, combinational (WORD_W bits) |
| ev_blk_start | output | 1 | One-cycle pulse: a block has started |
| ev_blk_end | output | 1 | One-cycle pulse: a block has completed and is visible |
| ev_cs_chg | output | 2 | Per-channel pulse: the completed status block differs from the previous one (NUM_CH bits) |

## Verification
A bit counter that is off by one shows as a shifted or rotated pattern in the read words. It becomes visible in the first block-end cycle, one cycle after the completing subframe. A corrupted stored status field shows as a missing or spurious status-changed pulse at the next block end. A stuck or wrongly cleared in-progress flag shows as a block-end pulse that is missing or arrives at the wrong time, or as stray bits from ignored subframes in the next visible block. Words that leak between block ends are caught by comparing reads taken in the middle of a block against the last completed block.

// File: rtl/spdif_cap_pkg.sv
// Shared types and helpers for the S/PDIF status/user capture block.
// Assumes byte addressing of the word-read port.
package spdif_cap_pkg;

    // One decoded subframe as seen by the per-channel collectors.
    typedef struct packed {
        logic valid;
        logic mark;
        logic cbit;
        logic ubit;
    } subframe_t;

    // Byte address of word w of a field for channel ch.
    function automatic int field_addr(input int base, input int stride,
                                      input int ch, input int w, input int wbytes);
        return base + ch * stride + w * wbytes;
    endfunction

endpackage

// File: rtl/spdif_cap_collect.sv
// Per-channel collector: gathers the C and U bits of one channel into
// BLK_BITS-wide fields and counts them. The next-state values are exported
// so that the top can commit a block in the same cycle as its last bit.
// Assumes the top supplies the shared in-progress flag.
module spdif_cap_collect
    import spdif_cap_pkg::*;
#(
    parameter int BLK_BITS = 192,
    parameter int CNT_W    = $clog2(BLK_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  subframe_t           sf,
    input  logic                chan_hit,
    input  logic                active,
    output logic                full_nxt,
    output logic [BLK_BITS-1:0] stat_nxt,
    output logic [BLK_BITS-1:0] user_nxt
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BLK_BITS);

    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic [BLK_BITS-1:0] stat_q, user_q;
    logic                full_q, take;
    logic [CNT_W-1:0]    wr_idx;

    assign full_q = (cnt_q == FULL_CNT);
    assign take   = sf.valid && chan_hit && (sf.mark || (active && !full_q));
    assign wr_idx = sf.mark ? '0 : cnt_q;

    // Next bit count: a marker restarts every channel, a taken bit advances.
    always_comb begin
        cnt_d = cnt_q;
        if (sf.valid && sf.mark)
            cnt_d = take ? CNT_W'(1) : '0;
        else if (take)
            cnt_d = cnt_q + CNT_W'(1);
    end

    // Next field contents: the taken bits land at the current index.
    always_comb begin
        stat_nxt = stat_q;
        user_nxt = user_q;
        if (take) begin
            stat_nxt[wr_idx] = sf.cbit;
            user_nxt[wr_idx] = sf.ubit;
        end
    end

    assign full_nxt = (cnt_d == FULL_CNT);

    // Hold the count and the partial fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            stat_q <= '0;
            user_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            stat_q <= stat_nxt;
            user_q <= user_nxt;
        end
    end
endmodule

// File: rtl/spdif_cap_bank.sv
// Per-channel visible bank: loads a completed block on commit and raises
// a one-cycle pulse when the new status field differs from the stored one.
// Assumes commit is a single-cycle strobe.
module spdif_cap_bank #(
    parameter int BLK_BITS = 192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic [BLK_BITS-1:0] stat_nxt,
    input  logic [BLK_BITS-1:0] user_nxt,
    output logic [BLK_BITS-1:0] stat_q,
    output logic [BLK_BITS-1:0] user_q,
    output logic                chg_ev
);
    // Load both fields together and flag a status difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            user_q <= '0;
            chg_ev <= 1'b0;
        end else begin
            chg_ev <= commit && (stat_nxt != stat_q);
            if (commit) begin
                stat_q <= stat_nxt;
                user_q <= user_nxt;
            end
        end
    end
endmodule

// File: rtl/spdif_cap_readmux.sv
// Word read port: decodes a byte address into one 32-bit slice of a
// channel's status or user field. Unmapped addresses return zero.
// Assumes every field is a whole number of words.
module spdif_cap_readmux
    import spdif_cap_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int BLK_BITS  = 192,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int STAT_BASE = 'h30
) (
    input  logic [NUM_CH-1:0][BLK_BITS-1:0] stat_all,
    input  logic [NUM_CH-1:0][BLK_BITS-1:0] user_all,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [WORD_W-1:0]               rd_data
);
    localparam int WORDS       = BLK_BITS / WORD_W;
    localparam int WBYTES      = WORD_W / 8;
    localparam int FIELD_BYTES = WORDS * WBYTES;
    localparam int USER_BASE   = STAT_BASE + FIELD_BYTES;
    localparam int CH_STRIDE   = 2 * FIELD_BYTES;

    // Select the addressed word, zero when nothing matches.
    always_comb begin
        rd_data = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            for (int w = 0; w < WORDS; w++) begin
                if (rd_addr == ADDR_W'(field_addr(STAT_BASE, CH_STRIDE, ch, w, WBYTES)))
                    rd_data = stat_all[ch][w*WORD_W +: WORD_W];
                if (rd_addr == ADDR_W'(field_addr(USER_BASE, CH_STRIDE, ch, w, WBYTES)))
                    rd_data = user_all[ch][w*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/spdif_aux_capture.sv
// Top of the S/PDIF channel-status and user-bit capture block. Tracks
// whether a block is in progress, commits all channels together when every
// channel is full, and drives the event pulses. Assumes one subframe per
// cycle at most and a marker on the first subframe of each block.
module spdif_aux_capture
    import spdif_cap_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int BLK_BITS  = 192,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int STAT_BASE = 'h30,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sf_valid,
    input  logic [CH_W-1:0]   sf_chan,
    input  logic              sf_cbit,
    input  logic              sf_ubit,
    input  logic              sf_blk_mark,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              ev_blk_start,
    output logic              ev_blk_end,
    output logic [NUM_CH-1:0] ev_cs_chg
);
    localparam int CNT_W = $clog2(BLK_BITS + 1);

    subframe_t                      sf_in;
    logic                           active_q, commit, mark_in;
    logic [NUM_CH-1:0]              full_nx;
    logic [NUM_CH-1:0][BLK_BITS-1:0] stat_nx, user_nx, stat_sh, user_sh;

    // Bundle the subframe fields for the collectors.
    always_comb begin
        sf_in.valid = sf_valid;
        sf_in.mark  = sf_blk_mark;
        sf_in.cbit  = sf_cbit;
        sf_in.ubit  = sf_ubit;
    end

    assign mark_in = sf_valid && sf_blk_mark;
    assign commit  = sf_valid && (sf_blk_mark || active_q) && (&full_nx);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        spdif_cap_collect #(.BLK_BITS(BLK_BITS), .CNT_W(CNT_W)) u_col (
            .clk      (clk),
            .rst_n    (rst_n),
            .sf       (sf_in),
            .chan_hit (sf_chan == CH_W'(g)),
            .active   (active_q),
            .full_nxt (full_nx[g]),
            .stat_nxt (stat_nx[g]),
            .user_nxt (user_nx[g])
        );
        spdif_cap_bank #(.BLK_BITS(BLK_BITS)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .commit   (commit),
            .stat_nxt (stat_nx[g]),
            .user_nxt (user_nx[g]),
            .stat_q   (stat_sh[g]),
            .user_q   (user_sh[g]),
            .chg_ev   (ev_cs_chg[g])
        );
    end

    // Block-in-progress flag: set by a marker, cleared by completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= 1'b0;
        else if (commit)
            active_q <= 1'b0;
        else if (mark_in)
            active_q <= 1'b1;
    end

    // One-cycle start and end pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_blk_start <= 1'b0;
            ev_blk_end   <= 1'b0;
        end else begin
            ev_blk_start <= mark_in;
            ev_blk_end   <= commit;
        end
    end

    spdif_cap_readmux #(
        .NUM_CH(NUM_CH), .BLK_BITS(BLK_BITS), .WORD_W(WORD_W),
        .ADDR_W(ADDR_W), .STAT_BASE(STAT_BASE)
    ) u_rd (
        .stat_all (stat_sh),
        .user_all (user_sh),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/spdif_cap_chk.sv
// Assertion checker for spdif_aux_capture, attached with bind.
// Assumes the bank registers of the top are named stat_sh and user_sh.
module spdif_cap_chk #(
    parameter int NUM_CH   = 2,
    parameter int BLK_BITS = 192,
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            sf_valid,
    input logic                            sf_blk_mark,
    input logic [ADDR_W-1:0]               rd_addr,
    input logic [WORD_W-1:0]               rd_data,
    input logic                            ev_blk_start,
    input logic                            ev_blk_end,
    input logic [NUM_CH-1:0]               ev_cs_chg,
    input logic [NUM_CH-1:0][BLK_BITS-1:0] stat_sh,
    input logic [NUM_CH-1:0][BLK_BITS-1:0] user_sh
);
    // R2
    blk_start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_blk_start |-> $past(sf_valid && sf_blk_mark));

    // R4
    blk_end_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_blk_end |-> $past(sf_valid));

    // R5
    words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_blk_end |-> ($stable(stat_sh) && $stable(user_sh)));

    // R6
    cs_chg_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_cs_chg) |-> ev_blk_end);

    // R3
    unaligned_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr[1:0] != 2'b00) |-> (rd_data == '0));

    // R8
    mark_not_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_blk_start |-> !ev_blk_end);
endmodule

bind spdif_aux_capture spdif_cap_chk #(
    .NUM_CH(NUM_CH), .BLK_BITS(BLK_BITS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sf_valid     (sf_valid),
    .sf_blk_mark  (sf_blk_mark),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .ev_blk_start (ev_blk_start),
    .ev_blk_end   (ev_blk_end),
    .ev_cs_chg    (ev_cs_chg),
    .stat_sh      (stat_sh),
    .user_sh      (user_sh)
);

// File: tb/spdif_aux_capture_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected event cycles and change
// masks into queues; a monitor pops and compares them as events appear.
module spdif_aux_capture_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sf_valid = 1'b0;
    logic [0:0]  sf_chan = '0;
    logic        sf_cbit = 1'b0, sf_ubit = 1'b0, sf_blk_mark = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        ev_blk_start, ev_blk_end;
    logic [1:0]  ev_cs_chg;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    int         start_q[$];
    int         end_cyc_q[$];
    logic [1:0] end_chg_q[$];
    logic [191:0] last_c[2], last_u[2];

    spdif_aux_capture uut (
        .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_chan(sf_chan),
        .sf_cbit(sf_cbit), .sf_ubit(sf_ubit), .sf_blk_mark(sf_blk_mark),
        .rd_addr(rd_addr), .rd_data(rd_data), .ev_blk_start(ev_blk_start),
        .ev_blk_end(ev_blk_end), .ev_cs_chg(ev_cs_chg)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [191:0] pat(input logic [31:0] s);
        logic [191:0] r;
        for (int w = 0; w < 6; w++)
            r[w*32 +: 32] = (s * 32'(w + 7)) ^ {s[15:0], s[31:16]} ^ 32'(w * 32'h01010101);
        return r;
    endfunction

    // Monitor: compare events against the scoreboard queues.
    always @(negedge clk) begin
        int e;
        logic [1:0] m;
        if (rst_n && !done) begin
            if (ev_blk_start) begin
                if (start_q.size() == 0) chk(0, "R2", "unexpected block start", cyc, 0);
                else begin e = start_q.pop_front(); chk(e == cyc, "R2", "block start cycle", cyc, e); end
            end
            if (ev_blk_end) begin
                if (end_cyc_q.size() == 0) chk(0, "R8", "unexpected block end", cyc, 0);
                else begin
                    e = end_cyc_q.pop_front();
                    m = end_chg_q.pop_front();
                    chk(e == cyc, "R4", "block end cycle", cyc, e);
                    chk(ev_cs_chg == m, "R6", "status change mask", ev_cs_chg, m);
                end
            end else if (ev_cs_chg != 2'b00) begin
                chk(0, "R6", "change pulse without block end", ev_cs_chg, 0);
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        sf_valid = 0; sf_blk_mark = 0; sf_cbit = 0; sf_ubit = 0;
    endtask

    task automatic send(input int ch, input logic c, input logic u, input logic m,
                        input bit fin, input logic [1:0] chg);
        @(negedge clk);
        sf_valid = 1; sf_chan = ch[0]; sf_cbit = c; sf_ubit = u; sf_blk_mark = m;
        if (m) start_q.push_back(cyc + 1);
        if (fin) begin end_cyc_q.push_back(cyc + 1); end_chg_q.push_back(chg); end
    endtask

    task automatic rd_chk(input int addr, input logic [31:0] exp, input string req);
        rd_addr = addr[7:0];
        #0.5;
        chk(rd_data == exp, req, $sformatf("word @%0h", addr), rd_data, exp);
    endtask

    task automatic fields_chk(input int ch, input logic [191:0] c, input logic [191:0] u,
                              input string req);
        for (int w = 0; w < 6; w++) begin
            rd_chk(32'h30 + ch * 32'h30 + w * 4, c[w*32 +: 32], req);
            rd_chk(32'h48 + ch * 32'h30 + w * 4, u[w*32 +: 32], req);
        end
    endtask

    task automatic both_chk(input string req);
        fields_chk(0, last_c[0], last_u[0], req);
        fields_chk(1, last_c[1], last_u[1], req);
    endtask

    // One block: interleaved or channel-sequential, optionally truncated.
    task automatic run_block(input logic [191:0] c0, input logic [191:0] u0,
                             input logic [191:0] c1, input logic [191:0] u1,
                             input int limit, input bit seq, input bit mid);
        logic [1:0] chg;
        bit full;
        full = (limit == 192);
        chg = {c1 != last_c[1], c0 != last_c[0]};
        if (!seq) begin
            for (int f = 0; f < limit; f++) begin
                send(0, c0[f], u0[f], f == 0, 0, 0);
                send(1, c1[f], u1[f], 0, full && f == 191, chg);
                if (mid && f == 96) begin
                    idle();
                    both_chk("R5");
                end
            end
        end else begin
            for (int f = 0; f < 192; f++) send(0, c0[f], u0[f], f == 0, 0, 0);
            for (int k = 0; k < 6; k++) send(0, 1'b1, 1'b1, 0, 0, 0); // R9 extras on full channel
            for (int f = 0; f < 192; f++) send(1, c1[f], u1[f], 0, f == 191, chg);
        end
        if (full) begin
            last_c[0] = c0; last_u[0] = u0; last_c[1] = c1; last_u[1] = u1;
        end
        idle();
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin last_c[i] = '0; last_u[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(ev_blk_start == 0 && ev_blk_end == 0 && ev_cs_chg == 0, "R1", "events after reset",
            {ev_blk_start, ev_blk_end, ev_cs_chg}, 0);
        both_chk("R1");

        // R1 / R9: unmarked subframes before any marker are ignored
        for (int k = 0; k < 20; k++) send(k % 2, 1'b1, 1'b1, 0, 0, 0);
        idle();
        both_chk("R9");

        // Block A: R2, R3, R4, R5 (mid-block), R6 (channel 1 status stays zero)
        run_block(pat(1), pat(2), '0, pat(3), 192, 0, 1);
        both_chk("R4");

        // R9: subframes after completion without a marker are ignored
        for (int k = 0; k < 10; k++) send(k % 2, k[0], ~k[0], 0, 0, 0);
        idle();
        both_chk("R9");

        // Block B: channel 0 status unchanged, channel 1 changed (R6)
        run_block(pat(1), pat(4), pat(5), pat(6), 192, 0, 0);
        both_chk("R6");

        // Block C: no status change, user words still refreshed (R7)
        run_block(pat(1), pat(7), pat(5), pat(8), 192, 0, 0);
        both_chk("R7");

        // Block D truncated at 100 frames, then block E (R8)
        run_block(pat(9), pat(20), pat(21), pat(22), 100, 0, 0);
        both_chk("R8");
        run_block(pat(9), pat(10), pat(5), pat(11), 192, 0, 0);
        both_chk("R8");

        // Block F: channels sent one after another with extras on full channel 0 (R2, R9)
        run_block(pat(9), pat(13), pat(12), pat(14), 192, 1, 0);
        both_chk("R9");

        // R3: unmapped and unaligned addresses read zero
        rd_chk(32'h00, 32'h0, "R3");
        rd_chk(32'h2C, 32'h0, "R3");
        rd_chk(32'h32, 32'h0, "R3");
        rd_chk(32'h49, 32'h0, "R3");
        rd_chk(32'h90, 32'h0, "R3");

        repeat (5) @(negedge clk);
        chk(start_q.size() == 0, "R2", "pending block starts", start_q.size(), 0);
        chk(end_cyc_q.size() == 0, "R4", "pending block ends", end_cyc_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule